// File: doc/BRIEF.md
# PWM Generator Channel with Deferred Register Commit

This block is one pulse-width-modulation channel. A single counter, bounded by an active period (load) value, feeds two comparators. Each comparator drives one output: the output rises when the counter passes through zero and falls when the counter equals that comparator's active threshold. The counter either counts down from the load value to zero and reloads, or counts up from zero to the load value and back down again.

Software never writes the active period or threshold values directly. Each of the three values has a write buffer. A per-value policy bit in the control word picks when the buffer is copied into the active register. Under the immediate policy the copy happens at the next counter zero. Under the synchronized policy the copy waits for a shared sync request, which several channels can receive together, and then happens at the first counter zero after that request. A debug request parks the counter at zero unless the control word tells the counter to ignore debug.

Top module: `pwm_gen_chan`

## Requirements
- R1: While reset is asserted, and after it is released with enable low, the counter reads 0 and both outputs are low.
- R2: While control bit 0 (enable) is 0, the counter is held at 0 and both outputs are low from the following cycle on.
- R3: With control bit 1 (mode) at 0, the counter steps down by one each cycle. When it is at 0 it loads the active period value, so the period is load+1 cycles.
- R4: With control bit 1 at 1, the counter rises by one from 0 to the active period value, then falls by one back to 0. The period is 2×load cycles, and the counter never exceeds the active period value.
- R5: With control bit 3 at 0, a written period value becomes active on the clock edge at which the counter leaves 0, and the counter reloads from it on that same edge.
- R6: With control bit 3 at 1, a written period value stays inactive across counter zeros until a sync request is seen. It then becomes active at the first counter zero after the cycle of that request. A request that arrives in the cycle of a commit is kept for the next zero.
- R7: Control bit 4 applies the policies of R5 and R6 to the compare A threshold.
- R8: Control bit 5 applies the policies of R5 and R6 to the compare B threshold.
- R9: A second write before the commit replaces the buffered value, and only the last write becomes active.
- R10: With control bit 2 at 0 and debug requested, the counter keeps running until it reads 0 and then stays at 0. It restarts on the first edge after the request drops.
- R11: With control bit 2 at 1, the debug request has no effect on counting.
- R12: Each output is registered. It goes low the cycle after the counter equals its active threshold, and otherwise goes high the cycle after the counter reads 0. Equality with the threshold wins over zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl | input | 6 | Control word: 0 enable, 1 mode, 2 run-in-debug, 3/4/5 sync policy for period/A/B |
| wr_load | input | 1 | Write strobe for the period buffer |
| wr_cmpa | input | 1 | Write strobe for the compare A buffer |
| wr_cmpb | input | 1 | Write strobe for the compare B buffer |
| wr_data | input | CNT_W | Data for whichever buffer is strobed |
| sync_req | input | 1 | Shared synchronous-update request pulse |
| dbg_req | input | 1 | Debug halt request |
| pwm_a | output | 1 | Output driven by comparator A |
| pwm_b | output | 1 | Output driven by comparator B |
| cnt_val | output | CNT_W | Current counter value |

## Verification
The assertions assume that the control word stays constant while enable is high. In particular, the counting mode never flips mid-period, because the ceiling check in up/down mode depends on the counter having started from zero under that mode. The stimulus changes the control word only after enable has been dropped and the counter has returned to zero. The assertions also assume at most one write strobe per cycle, since the strobes share one data bus, and the stimulus schedules each write in a cycle of its own. Debug requests and sync pulses may arrive in any cycle, including commit cycles.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  localparam int CTL_W      = 6;
  localparam int CTL_EN     = 0;
  localparam int CTL_MODE   = 1;
  localparam int CTL_DBGRUN = 2;
  localparam int CTL_SYNC0  = 3;  // policy bits for period, A, B follow in order
  localparam int NUM_SHADOW = 3;
  localparam int SH_LOAD    = 0;
  localparam int SH_CMPA    = 1;
  localparam int SH_CMPB    = 2;
  localparam int NUM_OUT    = 2;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         sync_mode,
  input  logic         sync_req,
  input  logic         zero_tick,
  output logic [W-1:0] act_q,
  output logic [W-1:0] act_nxt
);
  logic [W-1:0] buf_q;
  logic         pend_q, pend_d;
  logic         commit;

  always_comb begin
    commit  = zero_tick & (~sync_mode | pend_q);
    pend_d  = (sync_req & sync_mode) | (pend_q & ~commit);
    act_nxt = commit ? buf_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (wr_en) begin
      buf_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (commit) begin
      act_q <= buf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  AST_ACT_ONLY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_tick |=> $stable(act_q)); // R5
  AST_SYNC_GATES_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_tick && sync_mode && !pend_q) |=> $stable(act_q)); // R6
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_gen_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         updown,
  input  logic         stall,
  input  logic [W-1:0] load_nxt,
  input  logic [W-1:0] load_act,
  output logic [W-1:0] cnt_q
);
  localparam logic [W-1:0] ONE = W'(1);

  cnt_dir_e     dir_q, dir_d;
  logic [W-1:0] cnt_d;
  logic         at_zero;
  logic         cnt_ce;

  always_comb begin
    at_zero = (cnt_q == '0);
    cnt_ce  = ~(en & stall & at_zero);
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    if (!en) begin
      cnt_d = '0;
      dir_d = DIR_UP;
    end else if (at_zero) begin
      dir_d = DIR_UP;
      if (!updown) begin
        cnt_d = load_nxt;
      end else if (load_nxt != '0) begin
        cnt_d = ONE;
      end
    end else if (!updown) begin
      cnt_d = cnt_q - ONE;
    end else if (dir_q == DIR_UP && cnt_q < load_act) begin
      cnt_d = cnt_q + ONE;
    end else begin
      cnt_d = cnt_q - ONE;
      dir_d = DIR_DOWN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  AST_HELD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0)); // R2
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !updown && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE)); // R3
  AST_UPDN_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && updown) |-> (cnt_q <= load_act)); // R4
  AST_DBG_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stall && cnt_q == '0) |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/pwm_cmp_out.sv
module pwm_cmp_out #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] thresh,
  output logic         pwm_q
);
  logic pwm_d;

  always_comb begin
    if (!en) begin
      pwm_d = 1'b0;
    end else if (cnt == thresh) begin
      pwm_d = 1'b0;
    end else if (cnt == '0) begin
      pwm_d = 1'b1;
    end else begin
      pwm_d = pwm_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= pwm_d;
    end
  end

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_q); // R2
  AST_MATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt == thresh) |=> !pwm_q); // R12
  AST_ZERO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt == '0 && thresh != '0) |=> pwm_q); // R12
endmodule

// File: rtl/pwm_gen_chan.sv
module pwm_gen_chan
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       ctl,
  input  logic             wr_load,
  input  logic             wr_cmpa,
  input  logic             wr_cmpb,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             sync_req,
  input  logic             dbg_req,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic [CNT_W-1:0] cnt_val
);
  logic [1:0]            rst_sync_q;
  logic                  rst_int_n;
  logic                  en, stall, zero_tick;
  logic [NUM_SHADOW-1:0] wr_vec;
  logic [CNT_W-1:0]      act_q   [NUM_SHADOW];
  logic [CNT_W-1:0]      act_nxt [NUM_SHADOW];
  logic [CNT_W-1:0]      cnt_q;
  logic [NUM_OUT-1:0]    pwm_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    en        = ctl[CTL_EN];
    stall     = dbg_req & ~ctl[CTL_DBGRUN];
    zero_tick = en & (cnt_q == '0) & ~stall;
    wr_vec    = '0;
    wr_vec[SH_LOAD] = wr_load;
    wr_vec[SH_CMPA] = wr_cmpa;
    wr_vec[SH_CMPB] = wr_cmpb;
  end

  for (genvar i = 0; i < NUM_SHADOW; i++) begin : g_shadow
    pwm_shadow_reg #(.W(CNT_W)) u_shadow (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .wr_en     (wr_vec[i]),
      .wr_data   (wr_data),
      .sync_mode (ctl[CTL_SYNC0 + i]),
      .sync_req  (sync_req),
      .zero_tick (zero_tick),
      .act_q     (act_q[i]),
      .act_nxt   (act_nxt[i])
    );
  end

  pwm_counter #(.W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (en),
    .updown   (ctl[CTL_MODE]),
    .stall    (stall),
    .load_nxt (act_nxt[SH_LOAD]),
    .load_act (act_q[SH_LOAD]),
    .cnt_q    (cnt_q)
  );

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
    pwm_cmp_out #(.W(CNT_W)) u_out (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .en     (en),
      .cnt    (cnt_q),
      .thresh (act_q[SH_CMPA + j]),
      .pwm_q  (pwm_vec[j])
    );
  end

  assign pwm_a   = pwm_vec[0];
  assign pwm_b   = pwm_vec[1];
  assign cnt_val = cnt_q;

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_int_n |=> (cnt_val == '0 || !rst_int_n)); // R1
endmodule

// File: tb/pwm_gen_chan_test.sv
module pwm_gen_chan_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [5:0]   ctl = '0;
  logic         wr_load = 1'b0, wr_cmpa = 1'b0, wr_cmpb = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         sync_req = 1'b0, dbg_req = 1'b0;
  logic         pwm_a, pwm_b;
  logic [W-1:0] cnt_val;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_gen_chan #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .wr_load(wr_load), .wr_cmpa(wr_cmpa), .wr_cmpb(wr_cmpb),
    .wr_data(wr_data), .sync_req(sync_req), .dbg_req(dbg_req),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .cnt_val(cnt_val)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model built from the requirement text
  logic [W-1:0] m_cnt;
  logic         m_up;
  logic [W-1:0] m_buf [3];
  logic [W-1:0] m_act [3];
  logic [2:0]   m_pend;
  logic         m_a, m_b;

  always @(posedge clk or negedge rst_n) begin : mdl
    logic         zt;
    logic [2:0]   cm;
    logic [W-1:0] nact [3];
    if (!rst_n) begin
      m_cnt <= '0; m_up <= 1'b1; m_pend <= '0; m_a <= 1'b0; m_b <= 1'b0;
      for (int i = 0; i < 3; i++) begin
        m_buf[i] <= '0; m_act[i] <= '0;
      end
    end else begin
      zt = ctl[0] && (m_cnt == 0) && !(dbg_req && !ctl[2]);
      for (int i = 0; i < 3; i++) begin
        cm[i]   = zt && (!ctl[3+i] || m_pend[i]);
        nact[i] = cm[i] ? m_buf[i] : m_act[i];
        m_act[i]  <= nact[i];
        m_pend[i] <= (sync_req && ctl[3+i]) || (m_pend[i] && !cm[i]);
      end
      if (wr_load) m_buf[0] <= wr_data;
      if (wr_cmpa) m_buf[1] <= wr_data;
      if (wr_cmpb) m_buf[2] <= wr_data;
      m_a <= !ctl[0] ? 1'b0 : (m_cnt == m_act[1]) ? 1'b0 : (m_cnt == 0) ? 1'b1 : m_a;
      m_b <= !ctl[0] ? 1'b0 : (m_cnt == m_act[2]) ? 1'b0 : (m_cnt == 0) ? 1'b1 : m_b;
      if (!ctl[0]) begin
        m_cnt <= '0; m_up <= 1'b1;
      end else if (m_cnt == 0) begin
        if (zt) begin
          m_up <= 1'b1;
          if (!ctl[1]) m_cnt <= nact[0];
          else if (nact[0] != 0) m_cnt <= 1;
        end
      end else if (!ctl[1]) begin
        m_cnt <= m_cnt - 1;
      end else if (m_up && m_cnt < m_act[0]) begin
        m_cnt <= m_cnt + 1;
      end else begin
        m_cnt <= m_cnt - 1; m_up <= 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      check(cnt_val == m_cnt, ctl[1] ? "R4 counter" : "R3 counter", cnt_val, m_cnt);
      check(pwm_a == m_a, "R7 R12 pwm_a", pwm_a, m_a);
      check(pwm_b == m_b, "R8 R12 pwm_b", pwm_b, m_b);
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int which, input int val);
    wr_data = W'(val);
    wr_load = (which == 0); wr_cmpa = (which == 1); wr_cmpb = (which == 2);
    step();
    wr_load = 1'b0; wr_cmpa = 1'b0; wr_cmpb = 1'b0;
  endtask

  task automatic pulse_sync();
    sync_req = 1'b1; step(); sync_req = 1'b0;
  endtask

  task automatic wait_zero();
    while (cnt_val != 0) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    check(cnt_val == 0, "R1 counter in reset", cnt_val, 0);
    check(pwm_a == 0 && pwm_b == 0, "R1 outputs in reset", {pwm_a, pwm_b}, 0);
    rst_n = 1'b1;
    step(3);
    cmp_on = 1'b1;
    check(cnt_val == 0, "R1 counter after release", cnt_val, 0);

    // immediate policy, count-down
    wr(0, 5); wr(1, 2); wr(2, 4);
    check(cnt_val == 0, "R2 held while disabled", cnt_val, 0);
    ctl = 6'b000001;
    step();
    check(cnt_val == 5, "R5 load taken at first zero", cnt_val, 5);
    for (int k = 1; k <= 5; k++) begin
      step();
      check(cnt_val == W'((5 - k + 6) % 6), "R3 down sequence", cnt_val, (5 - k + 6) % 6);
    end
    step();
    check(cnt_val == 5, "R3 reload after zero", cnt_val, 5);

    // replacement before commit
    wr(0, 3); wr(0, 6);
    wait_zero(); step();
    check(cnt_val == 6, "R9 last write wins", cnt_val, 6);

    // synchronized period update
    ctl = 6'b001001;
    wr(0, 2);
    wait_zero(); step();
    check(cnt_val == 6, "R6 held without sync", cnt_val, 6);
    step(2);
    pulse_sync();
    wait_zero(); step();
    check(cnt_val == 2, "R6 commit after mid-period sync", cnt_val, 2);

    // debug halt at zero
    ctl = 6'b000001;
    while (cnt_val != 2) step();
    dbg_req = 1'b1;
    step();
    check(cnt_val == 1, "R10 runs on to zero", cnt_val, 1);
    for (int k = 0; k < 5; k++) begin
      step();
      check(cnt_val == 0, "R10 parked at zero", cnt_val, 0);
    end
    dbg_req = 1'b0;
    step();
    check(cnt_val == 2, "R10 resumes after release", cnt_val, 2);

    // debug ignored
    ctl = 6'b000101;
    dbg_req = 1'b1;
    wait_zero(); step();
    check(cnt_val == 2, "R11 runs through zero in debug", cnt_val, 2);
    dbg_req = 1'b0;

    ctl = 6'b000000;
    step();
    check(cnt_val == 0, "R2 counter cleared", cnt_val, 0);
    step();
    check(pwm_a == 0 && pwm_b == 0, "R2 outputs low", {pwm_a, pwm_b}, 0);

    // sweep over every mode/debug/policy combination
    for (int cfg = 0; cfg < 32; cfg++) begin
      ctl = 6'b000000;
      step(2);
      wr(0, 3 + cfg % 4); wr(1, 1 + cfg % 3); wr(2, 2);
      ctl = {cfg[4:0], 1'b1};
      for (int c = 0; c < 80; c++) begin
        if (c == 9)               wr(0, 2 + cfg % 5);
        else if (c == 15)         wr(1, cfg % 4);
        else if (c == 21)         wr(2, 1 + cfg % 3);
        else if (c == 26 + cfg % 9) pulse_sync();
        else if (c == 47)         wr(0, 0);
        else if (c == 49)         wr(0, 4);
        else if (c == 55)         pulse_sync();
        else begin
          dbg_req = (c >= 33 && c < 45);
          step();
        end
      end
      dbg_req = 1'b0;
    end
    ctl = 6'b000000;
    step(2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule